// File: doc/BRIEF.md
# Write Burst Command Scheduler

This block sits on the controller side of a double-data-rate SDRAM interface and sequences Write, Read and Precharge commands for a single bank. Requests arrive one at a time through a valid/ready handshake. Each request carries an operation, a bank, a column, a burst-length code, an auto-precharge flag and a cut flag. The block registers the chosen command onto a three-wire command code together with its address fields. When no command may go out, it drives NOP. A request that is blocked by a spacing rule is held until it can issue; it is never dropped.

Spacing is counted in clock cycles between command slots on the bus. Write data moves in pairs (one pair per clock), and a write with P pairs has its last pair P cycles after the command. The spacing windows after a write (write-to-read, write-to-precharge) and the precharge recovery time are taken from three programmable inputs. A later command either lets the earlier burst finish or cuts it short. When it cuts a burst short, the block pulses a truncation report that tells the write data path how many pairs are committed, so that the data path can mask the remaining beats.

The state machine has four states. IDLE means no timing window is open. WRITE means a plain write burst and its recovery windows are running. APRE means an auto-precharge write is running and its implied precharge recovery is in progress. PRECH means a precharge recovery count is running. The transitions are as follows. Accepting a write moves to WRITE, or to APRE when auto-precharge is set. Accepting a precharge moves to PRECH. Accepting a read moves to IDLE. In WRITE, APRE and PRECH, expiry of every open window with no request taken returns the machine to IDLE.

Top module: `wr_burst_sched`

## Requirements
- R1: After reset the command code is NOP (3'b111) and the truncation pulse is low; with no window open a write request is ready at once while the row is open.
- R2: The command code is {ras_n,cas_n,we_n}: NOP 3'b111, WRITE 3'b100, READ 3'b101, PRECHARGE 3'b010. It is registered one clock after acceptance, with cmd_col and cmd_bank taken from the request. cmd_ap equals the request flag for writes and is 0 for reads and precharges. Request operation codes: 0 write, 1 read, 2 precharge, 3 reserved (accepted, no command).
- R3: Burst-length code 0 gives 1 pair, code 1 gives 2 pairs, and codes 2 and 3 give 4 pairs.
- R4: A write may follow a plain write at any spacing k of one or more cycles. If k is below the earlier write's pair count P, a truncation report with k pairs is issued. If k is P or more, no report is issued and the bursts run back to back.
- R5: A read with the cut flag clear, following a plain write, issues no earlier than spacing P + t_wtr and causes no report.
- R6: A precharge with the cut flag clear, following a plain write, issues no earlier than spacing P + t_wr and causes no report.
- R7: A read or precharge with the cut flag set, following a plain write, issues without waiting. If its spacing k is below P + t (t is t_wtr for a read, t_wr for a precharge), a report with max(k − t, 0) pairs is issued.
- R8: After a precharge, the next command issues no earlier than t_rp cycles later, with a t_rp of 0 treated as 1.
- R9: After a write with auto-precharge, every next command waits until spacing P + t_wr + max(t_rp,1). The cut flag is ignored and no report is issued.
- R10: Reads and writes are held while row_open is low. Precharges are not.
- R11: A blocked request keeps rq_ready low and the bus at NOP; every accepted non-reserved request yields exactly one command.
- R12: A truncation report appears in the same cycle as the truncating command and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| row_open | input | 1 | Target row is open |
| t_wtr | input | TW | Write-to-read window in cycles |
| t_wr | input | TW | Write-to-precharge window in cycles |
| t_rp | input | TW | Precharge recovery in cycles |
| rq_valid | input | 1 | Request present |
| rq_ready | output | 1 | Request accepted this cycle when valid |
| rq_op | input | 2 | Operation code |
| rq_bank | input | BANK_W | Bank address |
| rq_col | input | COL_W | Starting column |
| rq_bl | input | 2 | Burst-length code |
| rq_ap | input | 1 | Auto-precharge enable |
| rq_cut | input | 1 | Allow cutting the running burst |
| cmd_code | output | 3 | Registered command code |
| cmd_bank | output | BANK_W | Bank address of the last command |
| cmd_col | output | COL_W | Column of the last command |
| cmd_ap | output | 1 | Auto-precharge bit of the last command |
| trunc_vld | output | 1 | Truncation report pulse |
| trunc_pairs | output | 3 | Committed pair count of the cut burst |

## Verification
A wrong state or a wrong window count shows up at the ports as a command slot that moves. A read or precharge comes out one or more cycles early or late compared with the bench's predicted spacing, and this is visible in the very cycle it issues. A wrong latched pair count or state appears as a missing or extra truncation pulse, or as a wrong committed-pair value, on the truncating command itself. A lost recovery count (tRP or auto-precharge) allows the next command out too early. The random mix places commands at spacing one and at the window edges, so an off-by-one error is exposed within a few requests.

// File: rtl/wbs_pkg.sv
package wbs_pkg;
    typedef enum logic [1:0] {OP_WR = 2'd0, OP_RD = 2'd1, OP_PRE = 2'd2, OP_RSV = 2'd3} op_e;
    typedef enum logic [2:0] {CMD_NOP = 3'b111, CMD_WR = 3'b100, CMD_RD = 3'b101, CMD_PRE = 3'b010} cmd_e;
    typedef enum logic [1:0] {ST_IDLE, ST_WRITE, ST_APRE, ST_PRECH} st_e;

    function automatic logic [2:0] bl_pairs(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction
endpackage

// File: rtl/wbs_rpcnt.sv
module wbs_rpcnt #(
    parameter int TW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [TW-1:0] t_rp,
    output logic          zero
);
    logic [TW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= (t_rp == '0) ? '0 : t_rp - 1'b1;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign zero = (cnt == '0);
endmodule

// File: rtl/wbs_age.sv
module wbs_age #(
    parameter int AGE_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    output logic [AGE_W-1:0] age
);
    always_ff @(posedge clk) begin
        if (!rst_n)
            age <= '0;
        else if (clr)
            age <= '0;
        else if (age != '1)
            age <= age + 1'b1;
    end
endmodule

// File: rtl/wbs_gate.sv
module wbs_gate
    import wbs_pkg::*;
#(
    parameter int AGE_W = 6,
    parameter int TW    = 4
) (
    input  st_e              st,
    input  op_e              op,
    input  logic             cut,
    input  logic             row_open,
    input  logic [AGE_W-1:0] age,
    input  logic [2:0]       pairs,
    input  logic [TW-1:0]    t_wtr,
    input  logic [TW-1:0]    t_wr,
    input  logic [TW-1:0]    t_rp,
    input  logic             rp_zero,
    output logic             allow,
    output logic             trunc,
    output logic [2:0]       vpairs,
    output logic             done
);
    localparam int SW = AGE_W + 2;

    logic [SW-1:0] k, rp_eff, need_rd, need_pr, need_ap, need_any;
    logic          row_ok;

    always_comb begin
        k        = SW'(age) + SW'(1);
        rp_eff   = (t_rp == '0) ? SW'(1) : SW'(t_rp);
        need_rd  = SW'(pairs) + SW'(t_wtr);
        need_pr  = SW'(pairs) + SW'(t_wr);
        need_ap  = need_pr + rp_eff;
        need_any = (need_rd > need_pr) ? need_rd : need_pr;
        row_ok   = (op == OP_PRE) || (op == OP_RSV) || row_open;
        allow    = 1'b0;
        trunc    = 1'b0;
        vpairs   = 3'd0;
        done     = 1'b0;
        unique case (st)
            ST_IDLE: begin
                allow = row_ok;
            end
            ST_PRECH: begin
                done  = rp_zero;
                allow = rp_zero && row_ok;
            end
            ST_APRE: begin
                done  = (k >= need_ap);
                allow = done && row_ok;
            end
            ST_WRITE: begin
                done = (k >= need_any);
                unique case (op)
                    OP_WR: begin
                        allow  = row_open;
                        trunc  = (k < SW'(pairs));
                        vpairs = k[2:0];
                    end
                    OP_RD: begin
                        allow  = row_open && (cut || k >= need_rd);
                        trunc  = (k < need_rd);
                        vpairs = (k > SW'(t_wtr)) ? 3'(k - SW'(t_wtr)) : 3'd0;
                    end
                    OP_PRE: begin
                        allow  = cut || k >= need_pr;
                        trunc  = (k < need_pr);
                        vpairs = (k > SW'(t_wr)) ? 3'(k - SW'(t_wr)) : 3'd0;
                    end
                    default: allow = 1'b1;
                endcase
            end
        endcase
    end
endmodule

// File: rtl/wr_burst_sched.sv
module wr_burst_sched
    import wbs_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int BANK_W = 2,
    parameter int TW     = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_open,
    input  logic [TW-1:0]     t_wtr,
    input  logic [TW-1:0]     t_wr,
    input  logic [TW-1:0]     t_rp,
    input  logic              rq_valid,
    output logic              rq_ready,
    input  logic [1:0]        rq_op,
    input  logic [BANK_W-1:0] rq_bank,
    input  logic [COL_W-1:0]  rq_col,
    input  logic [1:0]        rq_bl,
    input  logic              rq_ap,
    input  logic              rq_cut,
    output logic [2:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              cmd_ap,
    output logic              trunc_vld,
    output logic [2:0]        trunc_pairs
);
    localparam int AGE_W = TW + 2;

    st_e              st_q, st_d;
    op_e              op;
    logic [2:0]       pairs_q, vpairs;
    logic [AGE_W-1:0] age;
    logic             rp_zero, allow, trunc, done, take;

    assign op       = op_e'(rq_op);
    assign take     = rq_valid && allow;
    assign rq_ready = allow;

    wbs_age #(.AGE_W(AGE_W)) u_age (
        .clk(clk), .rst_n(rst_n), .clr(take && op == OP_WR), .age(age)
    );

    wbs_rpcnt #(.TW(TW)) u_rp (
        .clk(clk), .rst_n(rst_n), .load(take && op == OP_PRE), .t_rp(t_rp), .zero(rp_zero)
    );

    wbs_gate #(.AGE_W(AGE_W), .TW(TW)) u_gate (
        .st(st_q), .op(op), .cut(rq_cut), .row_open(row_open), .age(age),
        .pairs(pairs_q), .t_wtr(t_wtr), .t_wr(t_wr), .t_rp(t_rp),
        .rp_zero(rp_zero), .allow(allow), .trunc(trunc), .vpairs(vpairs), .done(done)
    );

    // next-state logic
    always_comb begin
        st_d = st_q;
        if (take) begin
            unique case (op)
                OP_WR:  st_d = rq_ap ? ST_APRE : ST_WRITE;
                OP_RD:  st_d = ST_IDLE;
                OP_PRE: st_d = ST_PRECH;
                OP_RSV: st_d = st_q;
            endcase
        end else begin
            unique case (st_q)
                ST_IDLE:                      st_d = ST_IDLE;
                ST_WRITE, ST_APRE, ST_PRECH:  if (done) st_d = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            pairs_q <= 3'd1;
        end else begin
            st_q <= st_d;
            if (take && op == OP_WR)
                pairs_q <= bl_pairs(rq_bl);
        end
    end

    // registered command bus and truncation report
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_code    <= CMD_NOP;
            cmd_bank    <= '0;
            cmd_col     <= '0;
            cmd_ap      <= 1'b0;
            trunc_vld   <= 1'b0;
            trunc_pairs <= 3'd0;
        end else begin
            cmd_code  <= CMD_NOP;
            trunc_vld <= 1'b0;
            if (take) begin
                cmd_bank    <= rq_bank;
                cmd_col     <= rq_col;
                cmd_ap      <= 1'b0;
                trunc_vld   <= trunc && st_q == ST_WRITE && op != OP_RSV;
                trunc_pairs <= vpairs;
                unique case (op)
                    OP_WR:  begin cmd_code <= CMD_WR; cmd_ap <= rq_ap; end
                    OP_RD:  cmd_code <= CMD_RD;
                    OP_PRE: cmd_code <= CMD_PRE;
                    OP_RSV: cmd_code <= CMD_NOP;
                endcase
            end
        end
    end

    p_cmd_legal_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_code inside {CMD_NOP, CMD_WR, CMD_RD, CMD_PRE});

    p_one_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rq_valid && rq_ready && op != OP_RSV) |=> cmd_code != CMD_NOP);

    p_trunc_src_r12: assert property (@(posedge clk) disable iff (!rst_n)
        trunc_vld |-> $past(st_q) == ST_WRITE);

    p_trunc_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
        trunc_vld |-> trunc_pairs < 3'd4);

    p_rp_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRECH && !rp_zero) |-> !rq_ready);

    p_row_block_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!row_open && (op == OP_WR || op == OP_RD)) |-> !rq_ready);

    p_ap_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_APRE && !done) |-> !rq_ready);
endmodule

// File: tb/sim_wr_burst_sched.sv
module sim_wr_burst_sched;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       row_open = 1'b1;
    logic [3:0] t_wtr = 4'd2, t_wr = 4'd3, t_rp = 4'd2;
    logic       rq_valid = 1'b0;
    logic       rq_ready;
    logic [1:0] rq_op = 2'd0;
    logic [1:0] rq_bank = 2'd0;
    logic [9:0] rq_col = 10'd0;
    logic [1:0] rq_bl = 2'd0;
    logic       rq_ap = 1'b0, rq_cut = 1'b0;
    logic [2:0] cmd_code;
    logic [1:0] cmd_bank;
    logic [9:0] cmd_col;
    logic       cmd_ap, trunc_vld;
    logic [2:0] trunc_pairs;

    int cyc = 0, total = 0, bad = 0;
    localparam int K_NONE = 0, K_WR = 1, K_WAP = 2, K_PRE = 3, K_RD = 4;
    int last_kind = K_NONE, lw = 0, lp = 1, lpre = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    wr_burst_sched u0 (
        .clk(clk), .rst_n(rst_n), .row_open(row_open), .t_wtr(t_wtr), .t_wr(t_wr), .t_rp(t_rp),
        .rq_valid(rq_valid), .rq_ready(rq_ready), .rq_op(rq_op), .rq_bank(rq_bank),
        .rq_col(rq_col), .rq_bl(rq_bl), .rq_ap(rq_ap), .rq_cut(rq_cut),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cmd_ap(cmd_ap),
        .trunc_vld(trunc_vld), .trunc_pairs(trunc_pairs)
    );

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int pairs_of(int bl);
        return (bl == 0) ? 1 : (bl == 1) ? 2 : 4;
    endfunction

    function automatic int rpe();
        return (t_rp == 0) ? 1 : int'(t_rp);
    endfunction

    function automatic int exp_time(int op, int cut, int s);
        int e = s;
        case (last_kind)
            K_WR: begin
                if (op == 0 || cut != 0) e = mx(s, lw + 1);
                else if (op == 1)        e = mx(s, lw + lp + int'(t_wtr));
                else                     e = mx(s, lw + lp + int'(t_wr));
            end
            K_WAP: e = mx(s, lw + lp + int'(t_wr) + rpe());
            K_PRE: e = mx(s, lpre + rpe());
            default: e = s;
        endcase
        return e;
    endfunction

    function automatic int exp_trunc(int op, int n);
        int k;
        if (last_kind != K_WR) return -1;
        k = n - lw;
        if (op == 0) return (k < lp) ? k : -1;
        if (op == 1) return (k < lp + int'(t_wtr)) ? mx(k - int'(t_wtr), 0) : -1;
        return (k < lp + int'(t_wr)) ? mx(k - int'(t_wr), 0) : -1;
    endfunction

    task automatic chk(bit ok, string req, string what, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; returns at the negedge the command is visible.
    task automatic do_req(int op, int bl, int ap, int cut, int hold, string tag);
        int s, e, n, w, et, col, bank, ecmd, quiet;
        col  = int'($urandom_range(0, 1023));
        bank = int'($urandom_range(0, 3));
        rq_op = 2'(op); rq_bl = 2'(bl); rq_ap = ap[0]; rq_cut = cut[0];
        rq_col = 10'(col); rq_bank = 2'(bank); rq_valid = 1'b1;
        if (hold > 0) begin
            row_open = 1'b0;
            quiet = 1;
            repeat (hold) begin
                @(negedge clk);
                if (cmd_code != 3'b111 || rq_ready) quiet = 0;
            end
            chk(quiet == 1, "R10", "held while row closed", quiet, 1);
            row_open = 1'b1;
        end
        s = cyc + 1;
        e = exp_time(op, cut, s);
        w = 0;
        do begin @(negedge clk); w++; end while (cmd_code == 3'b111 && w < 200);
        n = cyc;
        rq_valid = 1'b0;
        ecmd = (op == 0) ? 3'b100 : (op == 1) ? 3'b101 : 3'b010;
        chk(n == e, tag, "issue slot after request", n - s, e - s);
        chk(int'(cmd_code) == ecmd, "R2", "command code", int'(cmd_code), ecmd);
        if (op != 2) chk(int'(cmd_col) == col, "R2", "column", int'(cmd_col), col);
        chk(int'(cmd_bank) == bank, "R2", "bank", int'(cmd_bank), bank);
        chk(int'(cmd_ap) == ((op == 0) ? ap : 0), "R2", "ap bit", int'(cmd_ap), (op == 0) ? ap : 0);
        et = exp_trunc(op, n);
        chk(int'(trunc_vld) == ((et >= 0) ? 1 : 0), tag, "truncation pulse", int'(trunc_vld), (et >= 0) ? 1 : 0);
        if (et >= 0) chk(int'(trunc_pairs) == et, tag, "committed pairs", int'(trunc_pairs), et);
        if (op == 0) begin
            last_kind = (ap != 0) ? K_WAP : K_WR; lw = n; lp = pairs_of(bl);
        end else if (op == 2) begin
            last_kind = K_PRE; lpre = n;
        end else begin
            last_kind = K_RD;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(cmd_code == 3'b111, "R1", "command after reset", int'(cmd_code), 7);
        chk(trunc_vld == 1'b0, "R1", "truncation after reset", int'(trunc_vld), 0);
        chk(rq_ready == 1'b1, "R1", "ready with no window", int'(rq_ready), 1);

        // R4: back-to-back bursts of 4, no truncation at k = P
        do_req(0, 1, 0, 0, 0, "R4");
        idle(1);
        do_req(0, 1, 0, 0, 0, "R4");
        idle(10);
        // R4: burst of 8 cut by a write one cycle later
        do_req(0, 2, 0, 0, 0, "R4");
        do_req(0, 0, 0, 0, 0, "R4");
        idle(1);
        chk(trunc_vld == 1'b0, "R12", "pulse width", int'(trunc_vld), 0);
        idle(10);
        // R5 and R3: read after burst of 4 waits P + t_wtr
        do_req(0, 1, 0, 0, 0, "R3");
        do_req(1, 0, 0, 0, 0, "R5");
        idle(10);
        do_req(0, 3, 0, 0, 0, "R3");
        do_req(1, 0, 0, 0, 0, "R3");
        idle(10);
        // R7: cut read right after a burst of 8
        do_req(0, 2, 0, 0, 0, "R4");
        do_req(1, 0, 0, 1, 0, "R7");
        idle(10);
        // R7 then R8: cut precharge at k = 4, next command waits t_rp
        do_req(0, 2, 0, 0, 0, "R4");
        idle(3);
        do_req(2, 0, 0, 1, 0, "R7");
        do_req(0, 1, 0, 0, 0, "R8");
        idle(10);
        // R6: uncut precharge after a burst of 2
        do_req(0, 0, 0, 0, 0, "R4");
        do_req(2, 0, 0, 0, 0, "R6");
        idle(10);
        // R9: auto-precharge write holds even a cut read
        do_req(0, 1, 1, 0, 0, "R9");
        do_req(1, 0, 0, 1, 0, "R9");
        idle(10);
        // R10: write held while the row is closed, precharge not held
        do_req(0, 1, 0, 0, 5, "R10");
        idle(10);
        row_open = 1'b0;
        do_req(2, 0, 0, 0, 0, "R10");
        row_open = 1'b1;
        idle(10);
        // R8: t_rp of zero behaves as one
        t_rp = 4'd0;
        do_req(2, 0, 0, 0, 0, "R8");
        do_req(1, 0, 0, 0, 0, "R8");
        idle(10);

        // constrained random segments (R4 R5 R6 R7 R8 R9 R11)
        for (int seg = 0; seg < 24; seg++) begin
            idle(40);
            t_wtr = 4'($urandom_range(0, 7));
            t_wr  = 4'($urandom_range(0, 7));
            t_rp  = 4'($urandom_range(0, 7));
            for (int i = 0; i < 16; i++) begin
                int op, r;
                r  = int'($urandom_range(0, 9));
                op = (r < 5) ? 0 : (r < 8) ? 1 : 2;
                do_req(op, int'($urandom_range(0, 3)), ($urandom_range(0, 4) == 0) ? 1 : 0,
                       int'($urandom_range(0, 1)), 0, "R11");
                idle(int'($urandom_range(0, 2)));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule